// File: doc/BRIEF.md
# Power Mode Control Register

This block is a special-function register that an 8-bit microcontroller core uses to control its power state. It decodes one SFR address and returns the register on reads from that address. It holds seven bits: a baud-doubling enable and a select for the meaning of the serial control register's top bit, both passed on to the serial port; a flag that records a cold start; two general-purpose flags; and two sleep requests.

Writing the light-sleep request stops the CPU clock and freezes the program counter, while the peripheral clocks keep running. Writing the deep-sleep request also stops the peripheral clocks. When both are requested, deep sleep wins. An enabled interrupt request wakes the core: hardware clears both request bits, so the core comes back to normal running and never drops into light sleep afterwards. A wake request in the same cycle as a sleep write cancels the entry.

Two resets reach the block. `por_ni` is the power-on reset and `rst_ni` is any other (warm) reset. Only the power-on reset sets the cold-start flag. A warm reset clears every other bit and leaves that flag as it was.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After power-on reset the register reads 8'h10, only the cold-start flag (bit 4) is set, both clock enables are 1 and pc_hold_o is 0.
- R2: A warm reset (rst_ni low, por_ni high) clears bits 7, 6, 3, 2, 1 and 0, and the cold-start flag keeps the value it had before the reset (0 or 1).
- R3: Bit 5 always reads 0 and ignores writes. Writes to any address other than REG_ADDR (default 8'h87) change nothing, and reads from other addresses return 8'h00.
- R4: Writing 0 to bit 4 clears the cold-start flag. Writing 1 to bit 4 never sets it.
- R5: Bits 7 (baud doubling), 6 (serial top-bit select), 3 and 2 (general flags) are read/write. baud_dbl_o follows bit 7. ser_top_sel_o follows bit 6, where 1 selects the framing-error flag and 0 selects the mode bit.
- R6: Writing bit 0 = 1 with bit 1 = 0 gives, from the next cycle on, cpu_clk_en_o = 0, pc_hold_o = 1 and per_clk_en_o = 1.
- R7: Writing bit 1 = 1 gives, from the next cycle on, cpu_clk_en_o = 0, per_clk_en_o = 0 and pc_hold_o = 1.
- R8: Writing bits 1 and 0 both as 1 behaves as deep sleep (both clocks off). After the wake, the block returns to normal running with both bits read as 0, and it does not stay in light sleep.
- R9: A wake request wake_i[k] that is enabled by wake_en_i[k] clears bits 1 and 0. Both clocks are enabled and pc_hold_o is 0 in the cycle after the request is sampled. A request whose enable bit is 0 has no effect.
- R10: An enabled wake request in the same cycle as a write that sets bit 1 or bit 0 cancels the entry: in the next cycle pc_hold_o is 0 and both bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on clock |
| rst_ni | input | 1 | Warm reset, asynchronous, active low |
| por_ni | input | 1 | Power-on reset, asynchronous, active low |
| sfr_addr_i | input | ADDR_W | SFR address |
| sfr_wr_i | input | 1 | SFR write strobe |
| sfr_rd_i | input | 1 | SFR read strobe |
| sfr_wdata_i | input | 8 | SFR write data |
| sfr_rdata_o | output | 8 | Read data, 0 unless the register is being read |
| wake_i | input | NUM_WAKE | Wake requests from the interrupt sources |
| wake_en_i | input | NUM_WAKE | Per-source wake enables |
| cpu_clk_en_o | output | 1 | CPU clock-gate enable |
| per_clk_en_o | output | 1 | Peripheral clock-gate enable |
| pc_hold_o | output | 1 | Program-counter hold |
| baud_dbl_o | output | 1 | Serial baud-doubling enable |
| ser_top_sel_o | output | 1 | Serial control top-bit select (1 = framing-error flag) |

## Verification
A write is captured at one rising edge, and the read data and every output reflect it one cycle later. Reads are combinational, so the value is due in the same cycle as the read strobe. A wake request sampled at an edge makes the clocks run again in the cycle after that edge. The bench drives all inputs on the falling edge and samples on the next falling edge, which puts every check exactly one register stage after its stimulus. The bench also holds sleep states for several cycles with disabled wake sources to show that nothing changes.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  localparam int unsigned DW = 8;

  localparam int unsigned B_SMOD   = 7;
  localparam int unsigned B_SERSEL = 6;
  localparam int unsigned B_RSVD   = 5;
  localparam int unsigned B_POF    = 4;
  localparam int unsigned B_GF1    = 3;
  localparam int unsigned B_GF0    = 2;
  localparam int unsigned B_PD     = 1;
  localparam int unsigned B_IDL    = 0;

  typedef enum logic [1:0] {
    PM_RUN  = 2'd0,
    PM_IDLE = 2'd1,
    PM_DOWN = 2'd2
  } pmode_e;

  typedef struct packed {
    logic smod;
    logic sersel;
    logic pof;
    logic gf1;
    logic gf0;
  } cfg_t;
endpackage

// File: rtl/pmc_wake_merge.sv
module pmc_wake_merge #(
  parameter int unsigned NUM_WAKE = 4
) (
  input  logic [NUM_WAKE-1:0] wake_i,
  input  logic [NUM_WAKE-1:0] wake_en_i,
  output logic                wake_any_o
);
  logic [NUM_WAKE-1:0] masked;

  for (genvar g = 0; g < NUM_WAKE; g++) begin : g_mask
    assign masked[g] = wake_i[g] & wake_en_i[g];
  end

  assign wake_any_o = |masked;
endmodule

// File: rtl/pmc_sfr_regs.sv
module pmc_sfr_regs
  import pmc_pkg::*;
#(
  parameter int unsigned     ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h87
) (
  input  logic              clk_i,
  input  logic              arst_ni,
  input  logic              por_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              pd_i,
  input  logic              idl_i,
  output logic              wr_hit_o,
  output cfg_t              cfg_o,
  output logic [DW-1:0]     rdata_o
);
  logic hit;
  logic unused_rsvd_w;
  logic unused_mode_w;
  logic smod_q, sersel_q, gf1_q, gf0_q, pof_q;
  logic [DW-1:0] reg_val;

  assign hit           = (addr_i == REG_ADDR);
  assign wr_hit_o      = wr_i & hit;
  assign unused_rsvd_w = wdata_i[B_RSVD];
  assign unused_mode_w = wdata_i[B_PD] ^ wdata_i[B_IDL];

  // cleared by any reset
  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      smod_q   <= 1'b0;
      sersel_q <= 1'b0;
      gf1_q    <= 1'b0;
      gf0_q    <= 1'b0;
    end else if (wr_hit_o) begin
      smod_q   <= wdata_i[B_SMOD];
      sersel_q <= wdata_i[B_SERSEL];
      gf1_q    <= wdata_i[B_GF1];
      gf0_q    <= wdata_i[B_GF0];
    end
  end

  // cold-start flag: only the power-on reset sets it, software may only clear it
  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni)       pof_q <= 1'b1;
    else if (wr_hit_o) pof_q <= pof_q & wdata_i[B_POF];
  end

  always_comb begin
    reg_val           = '0;
    reg_val[B_SMOD]   = smod_q;
    reg_val[B_SERSEL] = sersel_q;
    reg_val[B_POF]    = pof_q;
    reg_val[B_GF1]    = gf1_q;
    reg_val[B_GF0]    = gf0_q;
    reg_val[B_PD]     = pd_i;
    reg_val[B_IDL]    = idl_i;
  end

  assign rdata_o = (rd_i && hit) ? reg_val : '0;
  assign cfg_o   = '{smod: smod_q, sersel: sersel_q, pof: pof_q, gf1: gf1_q, gf0: gf0_q};

  AST_POF_NEVER_SET: assert property (@(posedge clk_i) disable iff (!por_ni)
    !pof_q |=> !pof_q) else $error("pof set by software"); // R4

  AST_OFF_ADDR_NO_WRITE: assert property (@(posedge clk_i) disable iff (!arst_ni)
    (wr_i && !hit) |=> ($stable(gf1_q) && $stable(gf0_q) && $stable(smod_q) && $stable(sersel_q)))
    else $error("write to foreign address changed state"); // R3
endmodule

// File: rtl/pmc_mode_ctrl.sv
module pmc_mode_ctrl
  import pmc_pkg::*;
(
  input  logic   clk_i,
  input  logic   arst_ni,
  input  logic   wr_hit_i,
  input  logic   wr_pd_i,
  input  logic   wr_idl_i,
  input  logic   wake_i,
  output logic   pd_o,
  output logic   idl_o,
  output pmode_e mode_o,
  output logic   cpu_clk_en_o,
  output logic   per_clk_en_o,
  output logic   pc_hold_o
);
  logic pd_q, idl_q;

  // a wake clears both requests and also beats a same-cycle sleep write
  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      pd_q  <= 1'b0;
      idl_q <= 1'b0;
    end else if (wake_i) begin
      pd_q  <= 1'b0;
      idl_q <= 1'b0;
    end else if (wr_hit_i) begin
      pd_q  <= wr_pd_i;
      idl_q <= wr_idl_i;
    end
  end

  always_comb begin
    if (pd_q)       mode_o = PM_DOWN;
    else if (idl_q) mode_o = PM_IDLE;
    else            mode_o = PM_RUN;
  end

  assign cpu_clk_en_o = (mode_o == PM_RUN);
  assign per_clk_en_o = (mode_o != PM_DOWN);
  assign pc_hold_o    = (mode_o != PM_RUN);
  assign pd_o         = pd_q;
  assign idl_o        = idl_q;

  AST_IDLE_ENTRY: assert property (@(posedge clk_i) disable iff (!arst_ni)
    (wr_hit_i && wr_idl_i && !wr_pd_i && !wake_i) |=> (!cpu_clk_en_o && per_clk_en_o && pc_hold_o))
    else $error("idle entry wrong"); // R6

  AST_PD_ENTRY: assert property (@(posedge clk_i) disable iff (!arst_ni)
    (wr_hit_i && wr_pd_i && !wake_i) |=> (!cpu_clk_en_o && !per_clk_en_o && pc_hold_o))
    else $error("power-down entry wrong"); // R7

  AST_PD_NO_IDLE_AFTER: assert property (@(posedge clk_i) disable iff (!arst_ni)
    (pd_q && wake_i) |=> (mode_o == PM_RUN)) else $error("idle after power-down"); // R8

  AST_CANCEL_ENTRY: assert property (@(posedge clk_i) disable iff (!arst_ni)
    (wr_hit_i && (wr_pd_i || wr_idl_i) && wake_i) |=> !pc_hold_o)
    else $error("entry not cancelled"); // R10
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int unsigned       ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h87,
  parameter int unsigned       NUM_WAKE = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                por_ni,
  input  logic [ADDR_W-1:0]   sfr_addr_i,
  input  logic                sfr_wr_i,
  input  logic                sfr_rd_i,
  input  logic [DW-1:0]       sfr_wdata_i,
  output logic [DW-1:0]       sfr_rdata_o,
  input  logic [NUM_WAKE-1:0] wake_i,
  input  logic [NUM_WAKE-1:0] wake_en_i,
  output logic                cpu_clk_en_o,
  output logic                per_clk_en_o,
  output logic                pc_hold_o,
  output logic                baud_dbl_o,
  output logic                ser_top_sel_o
);
  logic   arst_n;
  logic   wr_hit;
  logic   wake_any;
  logic   pd, idl;
  cfg_t   cfg;
  pmode_e mode;
  logic   unused_mode;

  assign arst_n = rst_ni & por_ni;

  pmc_wake_merge #(.NUM_WAKE(NUM_WAKE)) u_wake (
    .wake_i    (wake_i),
    .wake_en_i (wake_en_i),
    .wake_any_o(wake_any)
  );

  pmc_sfr_regs #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_regs (
    .clk_i   (clk_i),
    .arst_ni (arst_n),
    .por_ni  (por_ni),
    .addr_i  (sfr_addr_i),
    .wr_i    (sfr_wr_i),
    .rd_i    (sfr_rd_i),
    .wdata_i (sfr_wdata_i),
    .pd_i    (pd),
    .idl_i   (idl),
    .wr_hit_o(wr_hit),
    .cfg_o   (cfg),
    .rdata_o (sfr_rdata_o)
  );

  pmc_mode_ctrl u_mode (
    .clk_i       (clk_i),
    .arst_ni     (arst_n),
    .wr_hit_i    (wr_hit),
    .wr_pd_i     (sfr_wdata_i[B_PD]),
    .wr_idl_i    (sfr_wdata_i[B_IDL]),
    .wake_i      (wake_any),
    .pd_o        (pd),
    .idl_o       (idl),
    .mode_o      (mode),
    .cpu_clk_en_o(cpu_clk_en_o),
    .per_clk_en_o(per_clk_en_o),
    .pc_hold_o   (pc_hold_o)
  );

  assign unused_mode   = ^mode ^ cfg.pof ^ cfg.gf1 ^ cfg.gf0;
  assign baud_dbl_o    = cfg.smod;
  assign ser_top_sel_o = cfg.sersel;

  AST_WAKE_RESUMES: assert property (@(posedge clk_i) disable iff (!arst_n)
    (pc_hold_o && |(wake_i & wake_en_i)) |=> (cpu_clk_en_o && per_clk_en_o && !pc_hold_o))
    else $error("wake did not resume"); // R9

  AST_HOLD_WITHOUT_WAKE: assert property (@(posedge clk_i) disable iff (!arst_n)
    (pc_hold_o && !(|(wake_i & wake_en_i)) && !sfr_wr_i) |=> pc_hold_o)
    else $error("left sleep without wake"); // R9
endmodule

// File: tb/sim_pwr_mode_ctrl.sv
`timescale 1ns/1ps
module sim_pwr_mode_ctrl;
  logic       clk = 1'b0;
  logic       rst_n, por_n;
  logic [7:0] addr, wdata, rdata;
  logic       wr, rd;
  logic [3:0] wake, wake_en;
  logic       cpu_en, per_en, hold, baud, sel;
  int         n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  pwr_mode_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .por_ni(por_n),
    .sfr_addr_i(addr), .sfr_wr_i(wr), .sfr_rd_i(rd),
    .sfr_wdata_i(wdata), .sfr_rdata_o(rdata),
    .wake_i(wake), .wake_en_i(wake_en),
    .cpu_clk_en_o(cpu_en), .per_clk_en_o(per_en), .pc_hold_o(hold),
    .baud_dbl_o(baud), .ser_top_sel_o(sel)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic sfr_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic sfr_read(input logic [7:0] a, output logic [7:0] d);
    rd = 1'b1; addr = a;
    #1 d = rdata;
    rd = 1'b0;
  endtask

  task automatic chk_clk(input string tag, input logic c, input logic p, input logic h);
    chk({tag, " clocks"}, {5'd0, cpu_en, per_en, hold}, {5'd0, c, p, h});
  endtask

  task automatic do_por();
    @(negedge clk); por_n = 1'b0; rst_n = 1'b0;
    @(negedge clk); @(negedge clk); por_n = 1'b1; rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic do_warm();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_por();
    logic [7:0] v;
    do_por();
    sfr_read(8'h87, v);
    chk("R1 por value", v, 8'h10);
    chk_clk("R1", 1'b1, 1'b1, 1'b0);
  endtask

  task automatic t_rw();
    logic [7:0] v;
    sfr_write(8'h87, 8'hEC);
    sfr_read(8'h87, v);
    chk("R5/R3 rw readback, rsvd 0", v, 8'hCC);
    chk("R5 outputs", {6'd0, baud, sel}, 8'h03);
    sfr_write(8'h87, 8'h40);
    chk("R5 sel only", {6'd0, baud, sel}, 8'h01);
    sfr_write(8'h87, 8'h10);
    sfr_read(8'h87, v);
    chk("R4 pof write 1 ignored", v, 8'h00);
    sfr_write(8'h88, 8'hFF);
    sfr_read(8'h87, v);
    chk("R3 foreign write ignored", v, 8'h00);
    sfr_read(8'h88, v);
    chk("R3 foreign read zero", v, 8'h00);
  endtask

  task automatic t_warm();
    logic [7:0] v;
    sfr_write(8'h87, 8'hCC);
    do_warm();
    sfr_read(8'h87, v);
    chk("R2 warm keeps pof=0", v, 8'h00);
    do_por();
    sfr_write(8'h87, 8'hDC);
    sfr_read(8'h87, v);
    chk("R5 all rw set", v, 8'hDC);
    do_warm();
    sfr_read(8'h87, v);
    chk("R2 warm keeps pof=1", v, 8'h10);
    sfr_write(8'h87, 8'h00);
    sfr_read(8'h87, v);
    chk("R4 pof cleared", v, 8'h00);
  endtask

  task automatic t_idle();
    logic [7:0] v;
    wake_en = 4'b0010;
    sfr_write(8'h87, 8'h01);
    chk_clk("R6 idle", 1'b0, 1'b1, 1'b1);
    sfr_read(8'h87, v);
    chk("R6 idl bit", v, 8'h01);
    wake = 4'b0001;
    @(negedge clk); @(negedge clk);
    chk_clk("R9 disabled wake", 1'b0, 1'b1, 1'b1);
    wake = 4'b0010;
    @(negedge clk);
    wake = 4'b0000;
    chk_clk("R9 wake from idle", 1'b1, 1'b1, 1'b0);
    sfr_read(8'h87, v);
    chk("R9 idl cleared", v, 8'h00);
  endtask

  task automatic t_pd();
    logic [7:0] v;
    sfr_write(8'h87, 8'h02);
    chk_clk("R7 pd", 1'b0, 1'b0, 1'b1);
    repeat (3) @(negedge clk);
    chk_clk("R7 pd held", 1'b0, 1'b0, 1'b1);
    wake = 4'b0010;
    @(negedge clk);
    wake = 4'b0000;
    chk_clk("R9 wake from pd", 1'b1, 1'b1, 1'b0);
    sfr_read(8'h87, v);
    chk("R9 pd cleared", v, 8'h00);
  endtask

  task automatic t_both();
    logic [7:0] v;
    sfr_write(8'h87, 8'h03);
    chk_clk("R8 both is pd", 1'b0, 1'b0, 1'b1);
    wake = 4'b0010;
    @(negedge clk);
    wake = 4'b0000;
    chk_clk("R8 resume run", 1'b1, 1'b1, 1'b0);
    @(negedge clk); @(negedge clk);
    chk_clk("R8 no idle after", 1'b1, 1'b1, 1'b0);
    sfr_read(8'h87, v);
    chk("R8 bits cleared", v, 8'h00);
  endtask

  task automatic t_cancel();
    logic [7:0] v;
    @(negedge clk);
    addr = 8'h87; wdata = 8'h02; wr = 1'b1; wake = 4'b0010;
    @(negedge clk);
    wr = 1'b0; wake = 4'b0000;
    chk_clk("R10 cancel", 1'b1, 1'b1, 1'b0);
    sfr_read(8'h87, v);
    chk("R10 bits zero", v, 8'h00);
  endtask

  initial begin
    rst_n = 1'b0; por_n = 1'b0; addr = '0; wdata = '0; wr = 1'b0; rd = 1'b0;
    wake = '0; wake_en = '0;
    t_por();
    t_rw();
    t_warm();
    t_idle();
    t_pd();
    t_both();
    t_cancel();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule